// File: doc/BRIEF.md
# Ticket Lock Controller

This block arbitrates one shared critical section among a set of requester ports and hands it out strictly in the order the requests arrived. It keeps two counters: a dispenser value that is handed out as a ticket and then advanced, and a serving value that names the ticket now allowed in. A port that raises its acquire strobe is given a ticket in the same step that advances the dispenser. That port is then granted whenever its ticket matches the serving value. When the holder is finished it pulses release, and the serving value moves on by one.

Each port watches its own `granted` line and does not have to poll memory. If several ports ask in the same cycle, the lower-numbered port gets the lower ticket. A port holds at most one ticket at a time. A release from a port that is not the current holder changes nothing and raises a one-cycle error pulse.

Top module: `ticket_lock_unit`

## Requirements
- R1: During and right after reset, both counters are 0, no port holds a ticket, `granted` is all zero and `relErr` is 0.
- R2: An acquire pulse from a port that holds no ticket is sampled at a clock edge. After that edge `ticketValid` for that port is 1 and its `ticketOut` slice (bits `p*TICKET_W` upward) shows the dispenser value from before the edge. The dispenser advances by one for each ticket issued.
- R3: When several ports request in the same cycle, they receive consecutive tickets. Tickets are given in ascending port index, starting at the dispenser value.
- R4: A port is granted exactly while it holds a ticket equal to the serving value, so at most one `granted` bit is ever set.
- R5: A release from the granted port advances the serving value by one and clears that port's ticket. The port whose ticket equals the new serving value is granted after that same edge.
- R6: Grants are given in the order the tickets were issued.
- R7: A release from a port that is not granted leaves the serving value and all tickets unchanged. It sets `relErr` high for the one cycle after the edge at which it was sampled.
- R8: Both counters wrap modulo 2^TICKET_W. The ticket after 2^TICKET_W-1 is 0, and grants continue in order across the wrap.
- R9: An acquire from a port that already holds a ticket is ignored: its ticket stays the same and the dispenser does not advance.
- R10: After a reset, the first port to request is granted in the cycle right after its request edge, with ticket 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_PORTS | Per-port acquire pulse |
| relReq | input | NUM_PORTS | Per-port release pulse |
| ticketOut | output | NUM_PORTS*TICKET_W | Ticket held by each port, port p at bits p*TICKET_W upward |
| ticketValid | output | NUM_PORTS | Port holds a ticket |
| granted | output | NUM_PORTS | Port holds the lock |
| relErr | output | 1 | One-cycle pulse after a release from a non-holder |

## Verification
The bench builds the block with four ports and a three-bit ticket. With that setting the dispenser wraps after eight tickets, and one short sequence pushes both counters past the wrap while grants remain in order. Four ports is enough for every port to request in the same cycle, so the ordering by port index can be checked across all positions. The small ticket space also lets a single run mix releases, new requests and wrong releases in the same cycle on different ports.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;
  typedef struct packed {
    logic advanceServe;  // holder released: bump serving counter
    logic flagErr;       // some non-holder tried to release
  } lock_strobe_t;
endpackage

// File: rtl/ticket_lock_ctrl.sv
module ticket_lock_ctrl
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] acqReq,
  input  logic [NUM_PORTS-1:0] relReq,
  input  logic [NUM_PORTS-1:0] holdMask,
  input  logic [NUM_PORTS-1:0] grantMask,
  output logic [NUM_PORTS-1:0] issueMask,
  output logic [NUM_PORTS-1:0] dropMask,
  output lock_strobe_t         strobe
);
  // a port already holding a ticket cannot take a second one
  assign issueMask = acqReq & ~holdMask;
  // only the granted port may give the lock back
  assign dropMask  = relReq & grantMask;

  always_comb begin
    strobe              = '0;
    strobe.advanceServe = |dropMask;
    strobe.flagErr      = |(relReq & ~grantMask);
  end
endmodule

// File: rtl/ticket_lock_datapath.sv
module ticket_lock_datapath
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TICKET_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          issueMask,
  input  logic [NUM_PORTS-1:0]          dropMask,
  input  lock_strobe_t                  strobe,
  output logic [NUM_PORTS-1:0]          holdMask,
  output logic [NUM_PORTS-1:0]          grantMask,
  output logic [NUM_PORTS*TICKET_W-1:0] ticketFlat,
  output logic                          relErr
);
  localparam logic [TICKET_W-1:0] TICKET_ONE = TICKET_W'(1);

  logic [TICKET_W-1:0] nextTicket;
  logic [TICKET_W-1:0] nowServing;
  logic [TICKET_W-1:0] ticketReg [NUM_PORTS];
  logic [TICKET_W-1:0] offerTicket [NUM_PORTS];
  logic [TICKET_W-1:0] issuedTotal;

  // tickets for same-cycle requests follow port index order
  always_comb begin
    logic [TICKET_W-1:0] run;
    run = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      offerTicket[p] = nextTicket + run;
      if (issueMask[p]) run = run + TICKET_ONE;
    end
    issuedTotal = run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextTicket <= '0;
      nowServing <= '0;
      holdMask   <= '0;
      relErr     <= 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) ticketReg[p] <= '0;
    end else begin
      nextTicket <= nextTicket + issuedTotal;
      if (strobe.advanceServe) nowServing <= nowServing + TICKET_ONE;
      holdMask <= (holdMask & ~dropMask) | issueMask;
      relErr   <= strobe.flagErr;
      for (int p = 0; p < NUM_PORTS; p++)
        if (issueMask[p]) ticketReg[p] <= offerTicket[p];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign grantMask[g] = holdMask[g] && (ticketReg[g] == nowServing);
    assign ticketFlat[g*TICKET_W +: TICKET_W] = ticketReg[g];
  end
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TICKET_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          acqReq,
  input  logic [NUM_PORTS-1:0]          relReq,
  output logic [NUM_PORTS*TICKET_W-1:0] ticketOut,
  output logic [NUM_PORTS-1:0]          ticketValid,
  output logic [NUM_PORTS-1:0]          granted,
  output logic                          relErr
);
  // every port can hold one ticket, so the ticket space must cover all ports
  if (NUM_PORTS > (1 << TICKET_W)) begin : g_bad_width
    $error("ticket width too small for port count");
  end

  logic [NUM_PORTS-1:0] issueMask;
  logic [NUM_PORTS-1:0] dropMask;
  lock_strobe_t         strobe;

  ticket_lock_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .acqReq   (acqReq),
    .relReq   (relReq),
    .holdMask (ticketValid),
    .grantMask(granted),
    .issueMask(issueMask),
    .dropMask (dropMask),
    .strobe   (strobe)
  );

  ticket_lock_datapath #(.NUM_PORTS(NUM_PORTS), .TICKET_W(TICKET_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .issueMask (issueMask),
    .dropMask  (dropMask),
    .strobe    (strobe),
    .holdMask  (ticketValid),
    .grantMask (granted),
    .ticketFlat(ticketOut),
    .relErr    (relErr)
  );
endmodule

// File: rtl/ticket_lock_checker.sv
module ticket_lock_checker #(
  parameter int NUM_PORTS = 4,
  parameter int TICKET_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_PORTS-1:0]          acqReq,
  input logic [NUM_PORTS-1:0]          relReq,
  input logic [NUM_PORTS*TICKET_W-1:0] ticketOut,
  input logic [NUM_PORTS-1:0]          ticketValid,
  input logic [NUM_PORTS-1:0]          granted,
  input logic                          relErr
);
  assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    relErr |-> $past(|(relReq & ~granted)));

  assert_release_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(relReq & granted) |=> ((granted & $past(relReq & granted)) == '0));

  assert_issue_ticket_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(acqReq & ~ticketValid) |=>
      ((ticketValid & $past(acqReq & ~ticketValid)) == $past(acqReq & ~ticketValid)));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_keep
    assert_keep_ticket_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ticketValid[g] && acqReq[g] && !granted[g]) |=>
        $stable(ticketOut[g*TICKET_W +: TICKET_W]));
  end
endmodule

bind ticket_lock_unit ticket_lock_checker #(.NUM_PORTS(NUM_PORTS), .TICKET_W(TICKET_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acqReq     (acqReq),
  .relReq     (relReq),
  .ticketOut  (ticketOut),
  .ticketValid(ticketValid),
  .granted    (granted),
  .relErr     (relErr)
);

// File: tb/ticket_lock_unit_tb.sv
module ticket_lock_unit_tb;
  localparam int P = 4;
  localparam int W = 3;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0] acqReq = '0;
  logic [P-1:0] relReq = '0;
  logic [P*W-1:0] ticketOut;
  logic [P-1:0] ticketValid;
  logic [P-1:0] granted;
  logic relErr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  ticket_lock_unit #(.NUM_PORTS(P), .TICKET_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq),
    .ticketOut(ticketOut), .ticketValid(ticketValid),
    .granted(granted), .relErr(relErr)
  );

  typedef struct packed {
    logic [3:0]  acq;
    logic [3:0]  rel;
    logic [3:0]  eVal;
    logic [3:0]  eGnt;
    logic        eErr;
    logic [11:0] eTk;   // {t3,t2,t1,t0}, checked only where eVal is set
  } vec_t;

  // expected results worked out from the requirements, W=3 so tickets wrap at 8
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b0, 12'b000_000_000_000}, // R10 first
    '{4'b1110, 4'b0000, 4'b1111, 4'b0001, 1'b0, 12'b011_010_001_000}, // R3 same cycle
    '{4'b0000, 4'b0100, 4'b1111, 4'b0001, 1'b1, 12'b011_010_001_000}, // R7 bad release
    '{4'b0001, 4'b0000, 4'b1111, 4'b0001, 1'b0, 12'b011_010_001_000}, // R9 re-acquire
    '{4'b0000, 4'b0001, 4'b1110, 4'b0010, 1'b0, 12'b011_010_001_000}, // R5
    '{4'b0001, 4'b0000, 4'b1111, 4'b0010, 1'b0, 12'b011_010_001_100}, // R9 dispenser held
    '{4'b0000, 4'b0010, 4'b1101, 4'b0100, 1'b0, 12'b011_010_000_100}, // R6
    '{4'b0010, 4'b0100, 4'b1011, 4'b1000, 1'b0, 12'b011_000_101_100},
    '{4'b0100, 4'b1000, 4'b0111, 4'b0001, 1'b0, 12'b000_110_101_100},
    '{4'b1000, 4'b0001, 4'b1110, 4'b0010, 1'b0, 12'b111_110_101_000}, // ticket 7
    '{4'b0001, 4'b0000, 4'b1111, 4'b0010, 1'b0, 12'b111_110_101_000}, // R8 wrap to 0
    '{4'b0000, 4'b0010, 4'b1101, 4'b0100, 1'b0, 12'b111_110_000_000},
    '{4'b0000, 4'b0100, 4'b1001, 4'b1000, 1'b0, 12'b111_000_000_000},
    '{4'b0000, 4'b1000, 4'b0001, 4'b0001, 1'b0, 12'b000_000_000_000}, // serving wraps
    '{4'b0000, 4'b1010, 4'b0001, 4'b0001, 1'b1, 12'b000_000_000_000}, // R7 two bad
    '{4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b0, 12'b000_000_000_000},
    '{4'b1111, 4'b0000, 4'b1111, 4'b0001, 1'b0, 12'b100_011_010_001}  // R3 all four
  };

  task automatic check(input string tag, input int idx, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s step %0d actual=%0h expected=%0h", tag, idx, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", -1, 32'(ticketValid), 32'h0);
    check("R1 granted", -1, 32'(granted), 32'h0);
    check("R1 relErr", -1, 32'(relErr), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] mask;
      acqReq = VECS[i].acq;
      relReq = VECS[i].rel;
      @(negedge clk);
      for (int p = 0; p < P; p++) mask[p*W +: W] = {W{VECS[i].eVal[p]}};
      check("R2/R9 ticketValid", i, 32'(ticketValid), 32'(VECS[i].eVal));
      check("R4/R5/R6 granted", i, 32'(granted), 32'(VECS[i].eGnt));
      check("R7 relErr", i, 32'(relErr), 32'(VECS[i].eErr));
      check("R3/R8 tickets", i, 32'(ticketOut & mask), 32'(VECS[i].eTk & mask));
    end
    acqReq = '0;
    relReq = '0;

    // R10: reset in mid-activity, then the first requester wins at once
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 100, 32'(ticketValid), 32'h0);
    rst_n = 1'b1;
    acqReq = 4'b0100;
    @(negedge clk);
    acqReq = '0;
    check("R10 granted", 101, 32'(granted), 32'h4);
    check("R10 ticket", 101, 32'(ticketOut[2*W +: W]), 32'h0);
    // R7: non-holder release with no waiter leaves holder in place
    relReq = 4'b0001;
    @(negedge clk);
    relReq = '0;
    check("R7 pulse", 102, 32'(relErr), 32'h1);
    @(negedge clk);
    check("R7 pulse ends", 103, 32'(relErr), 32'h0);
    check("R7 holder kept", 103, 32'(granted), 32'h4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule